// File: doc/BRIEF.md
# Serial Flash Status Register and Write Guard

This block keeps the status register of a serial flash memory and decides, for every write-type command, whether the device carries it out. The command decoder hands it one decoded command at the moment chip select returns high, together with the number of serial clock bits counted during the frame. It also receives the byte loaded by a status write, the target address of a program or erase, and the level of the hardware write-protect pin. A one-cycle pulse from the program/erase timer ends a running operation.

On each write-type command the block returns exactly one of two pulses, accept or reject, one clock after the command. An accepted command updates the write-enable latch, loads the non-volatile status bits, or starts a busy cycle for the timer. A rejected command leaves every bit as it was. Read-type commands produce neither pulse. The whole register is always visible on `status` for status reads.

Top module: `flash_sr_guard`

## Requirements
- R1: `status` has the layout bit 7 = status-write lock, bit 6 = quad enable, bits 5..2 = block-protect level (bit 5 most significant), bit 1 = write-enable latch, bit 0 = busy, and reads 00h after reset.
- R2: Command kind 1 (write enable) sets the write-enable latch, and kind 2 (write disable) clears it. Neither needs the latch to be set.
- R3: A write-type command (kinds 1 to 6) is accepted only if its bit count is a multiple of 8 and fits its frame: 8 bits for kinds 1, 2 and 6, 16 for kind 3, 32 for kind 5, and at least 40 for kind 4. Any other count rejects the command and changes nothing.
- R4: An accepted status write (kind 3) copies bits 7..2 of `sr_wdata` into the register and sets busy. The write-enable latch stays at 1 until the cycle ends.
- R5: A status write is rejected while the lock bit is 1 and `wp_n` is 0, even with the write-enable latch set.
- R6: Kinds 3 to 6 are rejected when the write-enable latch is 0, and `status` then stays unchanged.
- R7: While busy is 1, every write-type command is rejected. Status read (kind 7) and array read (kind 0) produce neither pulse.
- R8: An `op_done` pulse while busy clears busy and the write-enable latch on the next clock. The non-volatile bits cannot change while busy is set.
- R9: A nonzero protect level b protects the top min(2^(b-1), 64) blocks of 64 KiB (defaults: 22-bit address, 16-bit block offset). A program (kind 4) or sector erase (kind 5) whose address falls in that area is rejected. An allowed one sets busy.
- R10: Chip erase (kind 6) is rejected whenever the protect level is nonzero and accepted, setting busy, when it is zero.
- R11: `cmd_accept` and `cmd_reject` are registered pulses in the cycle after `cmd_valid`, never both high. Non-write kinds raise neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | One-cycle strobe: a command frame ended (chip select rose) |
| cmd_kind | input | 3 | Decoded command kind, encoding as in R1..R11 |
| cmd_bits | input | BITS_W (12) | Serial clock bits counted in the frame |
| sr_wdata | input | 8 | Data byte carried by a status write |
| cmd_addr | input | ADDR_W (22) | Target address of a program or erase |
| wp_n | input | 1 | Hardware write-protect pin, active low |
| op_done | input | 1 | Pulse from the program/erase timer at the end of a cycle |
| cmd_accept | output | 1 | Pulse: the write-type command is carried out |
| cmd_reject | output | 1 | Pulse: the write-type command is refused |
| status | output | 8 | Current status register value |

## Verification
The in-line properties check several rules on every cycle. Accept and reject never coincide. A misaligned frame, a locked status write, a command without the latch, a command while busy, and a target in the protected area each never lead to an accept. The end-of-cycle pulse always clears busy and the latch, and a reject or a busy cycle never alters the register. Some behaviour only the scenario bench can show: the exact values loaded by a status write, the per-kind frame lengths, the growth of the protected region with the protect level, and the full sequence of latch and busy states across command chains.

// File: rtl/flash_sr_pkg.sv
// Package: shared command encoding and status bit positions for the
// flash status write guard. Assumes a 3-bit decoded command kind.
package flash_sr_pkg;

    typedef enum logic [2:0] {
        CMD_READ       = 3'd0,
        CMD_WREN       = 3'd1,
        CMD_WRDI       = 3'd2,
        CMD_WRSR       = 3'd3,
        CMD_PROG       = 3'd4,
        CMD_SECT_ERASE = 3'd5,
        CMD_CHIP_ERASE = 3'd6,
        CMD_STAT_READ  = 3'd7
    } cmd_kind_e;

    localparam int SR_BUSY  = 0;
    localparam int SR_WEL   = 1;
    localparam int SR_BP_LO = 2;
    localparam int SR_BP_HI = 5;
    localparam int SR_QE    = 6;
    localparam int SR_LOCK  = 7;
    localparam int BP_W     = SR_BP_HI - SR_BP_LO + 1;

    // True for the kinds that go through the accept/reject decision.
    function automatic logic is_write_kind(input cmd_kind_e k);
        return (k != CMD_READ) && (k != CMD_STAT_READ);
    endfunction

endpackage

// File: rtl/fsr_frame_check.sv
// Frame check: decides whether the bit count of a finished frame matches
// a whole-byte frame of the right length for its command kind.
// Assumes cmd_bits counts every serial clock seen while selected.
module fsr_frame_check
    import flash_sr_pkg::*;
#(
    parameter int BITS_W     = 12,
    parameter int ADDR_BYTES = 3
) (
    input  cmd_kind_e          kind,
    input  logic [BITS_W-1:0]  bits,
    output logic               frame_ok
);
    localparam int OP_LEN    = 8;
    localparam int SRW_LEN   = OP_LEN + 8;
    localparam int ERASE_LEN = OP_LEN + 8 * ADDR_BYTES;
    localparam int PROG_MIN  = ERASE_LEN + 8;

    logic aligned;
    assign aligned = (bits[2:0] == 3'b000);

    // Compare the count with the frame length this kind expects.
    always_comb begin
        unique case (kind)
            CMD_WREN, CMD_WRDI, CMD_CHIP_ERASE: frame_ok = aligned && (bits == BITS_W'(OP_LEN));
            CMD_WRSR:                            frame_ok = aligned && (bits == BITS_W'(SRW_LEN));
            CMD_SECT_ERASE:                      frame_ok = aligned && (bits == BITS_W'(ERASE_LEN));
            CMD_PROG:                            frame_ok = aligned && (bits >= BITS_W'(PROG_MIN));
            default:                             frame_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/fsr_region_decode.sv
// Region decode: maps the protect level to a protected area at the top of
// the array and flags whether the target block lies inside it.
// Assumes a power-of-two array split into 2**(ADDR_W-BLK_W) blocks.
module fsr_region_decode #(
    parameter int ADDR_W = 22,
    parameter int BLK_W  = 16,
    parameter int BP_W   = 4
) (
    input  logic [BP_W-1:0]    level,
    input  logic [ADDR_W-1:0]  addr,
    output logic               addr_prot,
    output logic               any_prot
);
    localparam int NBLK_W = ADDR_W - BLK_W;
    localparam int CNT_W  = NBLK_W + 1;
    localparam logic [CNT_W-1:0] NBLK = CNT_W'(1) << NBLK_W;

    logic [CNT_W-1:0] prot_cnt;
    logic [CNT_W-1:0] dist_top;
    logic             unused_offset;

    assign unused_offset = ^addr[BLK_W-1:0];

    // Protected block count doubles with each level step, capped at the array.
    always_comb begin
        if (level == '0) begin
            prot_cnt = '0;
        end else if ((int'(level) - 1) >= NBLK_W) begin
            prot_cnt = NBLK;
        end else begin
            prot_cnt = CNT_W'(1) << (int'(level) - 1);
        end
    end

    // Distance of the target block from the top end of the array.
    assign dist_top  = NBLK - {1'b0, addr[ADDR_W-1:BLK_W]};
    assign addr_prot = (prot_cnt != '0) && (dist_top <= prot_cnt);
    assign any_prot  = (level != '0);
endmodule

// File: rtl/fsr_status_reg.sv
// Status register storage: holds the non-volatile bits, the write-enable
// latch and the busy flag. Assumes the caller never loads or starts
// while busy is set.
module fsr_status_reg
    import flash_sr_pkg::*;
#(
    parameter logic [7:0] INIT_STATUS = 8'h00
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        set_wel,
    input  logic        clr_wel,
    input  logic        load_nv,
    input  logic [5:0]  nv_data,
    input  logic        start_busy,
    input  logic        op_done,
    output logic [7:0]  status
);
    logic [5:0] nv_q;
    logic       wel_q;
    logic       busy_q;

    // Non-volatile bits change only on an accepted status write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nv_q <= INIT_STATUS[7:2];
        end else if (load_nv) begin
            nv_q <= nv_data;
        end
    end

    // Latch and busy: end of cycle wins, otherwise apply command effects.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel_q  <= INIT_STATUS[SR_WEL];
            busy_q <= INIT_STATUS[SR_BUSY];
        end else if (op_done && busy_q) begin
            wel_q  <= 1'b0;
            busy_q <= 1'b0;
        end else begin
            if (set_wel)    wel_q  <= 1'b1;
            if (clr_wel)    wel_q  <= 1'b0;
            if (start_busy) busy_q <= 1'b1;
        end
    end

    assign status = {nv_q, wel_q, busy_q};

    assert_done_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && status[SR_BUSY]) |=> (!status[SR_BUSY] && !status[SR_WEL]));

    assert_busy_holds_nv_R8: assert property (@(posedge clk) disable iff (!rst_n)
        status[SR_BUSY] |=> $stable(status[7:2]));
endmodule

// File: rtl/flash_sr_guard.sv
// Top: status register and write-protect gate of a serial flash. Takes a
// decoded command when chip select rises and returns an accept or reject
// pulse one clock later, updating the status register on accept.
// Assumes cmd_valid is a single-cycle strobe per frame.
module flash_sr_guard
    import flash_sr_pkg::*;
#(
    parameter int         ADDR_W      = 22,
    parameter int         BLK_W       = 16,
    parameter int         BITS_W      = 12,
    parameter logic [7:0] INIT_STATUS = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_kind,
    input  logic [BITS_W-1:0] cmd_bits,
    input  logic [7:0]        sr_wdata,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              wp_n,
    input  logic              op_done,
    output logic              cmd_accept,
    output logic              cmd_reject,
    output logic [7:0]        status
);
    localparam int ADDR_BYTES = (ADDR_W + 7) / 8;

    cmd_kind_e kind;
    logic      frame_ok, addr_prot, any_prot;
    logic      busy, wel, lock;
    logic      rule_ok, is_wr, go;
    logic      set_wel, clr_wel, load_nv, start_busy;
    logic      unused_wdata;

    assign kind         = cmd_kind_e'(cmd_kind);
    assign busy         = status[SR_BUSY];
    assign wel          = status[SR_WEL];
    assign lock         = status[SR_LOCK];
    assign unused_wdata = ^sr_wdata[1:0];

    fsr_frame_check #(.BITS_W(BITS_W), .ADDR_BYTES(ADDR_BYTES)) u_frame (
        .kind     (kind),
        .bits     (cmd_bits),
        .frame_ok (frame_ok)
    );

    fsr_region_decode #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .BP_W(BP_W)) u_region (
        .level     (status[SR_BP_HI:SR_BP_LO]),
        .addr      (cmd_addr),
        .addr_prot (addr_prot),
        .any_prot  (any_prot)
    );

    // Per-kind permission on top of the frame and busy checks.
    always_comb begin
        unique case (kind)
            CMD_WREN, CMD_WRDI:        rule_ok = 1'b1;
            CMD_WRSR:                  rule_ok = wel && !(lock && !wp_n);
            CMD_PROG, CMD_SECT_ERASE:  rule_ok = wel && !addr_prot;
            CMD_CHIP_ERASE:            rule_ok = wel && !any_prot;
            default:                   rule_ok = 1'b0;
        endcase
    end

    assign is_wr      = cmd_valid && is_write_kind(kind);
    assign go         = is_wr && frame_ok && !busy && rule_ok;
    assign set_wel    = go && (kind == CMD_WREN);
    assign clr_wel    = go && (kind == CMD_WRDI);
    assign load_nv    = go && (kind == CMD_WRSR);
    assign start_busy = go && (kind inside {CMD_WRSR, CMD_PROG, CMD_SECT_ERASE, CMD_CHIP_ERASE});

    fsr_status_reg #(.INIT_STATUS(INIT_STATUS)) u_sr (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_wel    (set_wel),
        .clr_wel    (clr_wel),
        .load_nv    (load_nv),
        .nv_data    (sr_wdata[7:2]),
        .start_busy (start_busy),
        .op_done    (op_done),
        .status     (status)
    );

    // Register the decision pulses for the command decoder.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_accept <= 1'b0;
            cmd_reject <= 1'b0;
        end else begin
            cmd_accept <= go;
            cmd_reject <= is_wr && !go;
        end
    end

    assert_pulse_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_accept, cmd_reject}));

    assert_misaligned_refused_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_bits[2:0] != 3'b000)) |=> !cmd_accept);

    assert_locked_write_refused_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (kind == CMD_WRSR) && lock && !wp_n) |=> !cmd_accept);

    assert_no_latch_refused_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !wel && (kind inside {CMD_WRSR, CMD_PROG, CMD_SECT_ERASE, CMD_CHIP_ERASE}))
        |=> !cmd_accept);

    assert_reject_keeps_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_reject && !$past(op_done)) |-> (status == $past(status)));

    assert_busy_refuses_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && busy) |=> !cmd_accept);

    assert_protected_refused_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && addr_prot && (kind inside {CMD_PROG, CMD_SECT_ERASE})) |=> !cmd_accept);
endmodule

// File: tb/flash_sr_guard_test.sv
// Scoreboard bench: a driver task issues a command and queues the expected
// pulses and status; a monitor pops each item at the following negedge.
module flash_sr_guard_test;
    localparam int ADDR_W = 22;
    localparam int BITS_W = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [2:0]        cmd_kind = 3'd0;
    logic [BITS_W-1:0] cmd_bits = '0;
    logic [7:0]        sr_wdata = 8'h00;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic              wp_n = 1'b1;
    logic              op_done = 1'b0;
    logic              cmd_accept, cmd_reject;
    logic [7:0]        status;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic       acc;
        logic       rej;
        logic [7:0] st;
        string      tag;
    } exp_t;
    exp_t q[$];

    flash_sr_guard uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_bits(cmd_bits), .sr_wdata(sr_wdata), .cmd_addr(cmd_addr), .wp_n(wp_n),
        .op_done(op_done), .cmd_accept(cmd_accept), .cmd_reject(cmd_reject), .status(status)
    );

    always #4 clk = ~clk;

    // Driver: one command frame, then queue its expected result.
    task automatic issue(input logic [2:0] k, input int bits, input logic [7:0] d,
                         input logic [ADDR_W-1:0] a, input logic wp,
                         input logic ea, input logic er, input logic [7:0] est, input string tag);
        @(negedge clk);
        cmd_kind  = k;
        cmd_bits  = BITS_W'(bits);
        sr_wdata  = d;
        cmd_addr  = a;
        wp_n      = wp;
        cmd_valid = 1'b1;
        @(posedge clk);
        q.push_back('{ea, er, est, tag});
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // Driver: end-of-cycle pulse from the timer.
    task automatic finish_op(input logic [7:0] est, input string tag);
        @(negedge clk);
        op_done = 1'b1;
        @(posedge clk);
        q.push_back('{1'b0, 1'b0, est, tag});
        @(negedge clk);
        op_done = 1'b0;
    endtask

    // Monitor: compare outputs with the oldest queued expectation.
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (cmd_accept !== e.acc || cmd_reject !== e.rej || status !== e.st) begin
                    errors++;
                    $display("FAIL %s: acc=%b rej=%b status=%h, expected acc=%b rej=%b status=%h",
                             e.tag, cmd_accept, cmd_reject, status, e.acc, e.rej, e.st);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (status !== 8'h00 || cmd_accept !== 1'b0 || cmd_reject !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: status=%h acc=%b rej=%b, expected status=00 acc=0 rej=0",
                     status, cmd_accept, cmd_reject);
        end

        issue(3'd1, 8,  8'h00, '0, 1'b1, 1'b1, 1'b0, 8'h02, "R2 write enable");
        issue(3'd2, 8,  8'h00, '0, 1'b1, 1'b1, 1'b0, 8'h00, "R2 write disable");
        issue(3'd1, 9,  8'h00, '0, 1'b1, 1'b0, 1'b1, 8'h00, "R3 enable with 9 bits");
        issue(3'd3, 16, 8'h0C, '0, 1'b1, 1'b0, 1'b1, 8'h00, "R6 status write without latch");
        issue(3'd1, 8,  8'h00, '0, 1'b1, 1'b1, 1'b0, 8'h02, "R2 enable again");
        issue(3'd3, 15, 8'hC4, '0, 1'b1, 1'b0, 1'b1, 8'h02, "R3 status write 15 bits");
        issue(3'd3, 16, 8'hC7, '0, 1'b1, 1'b1, 1'b0, 8'hC7, "R4 status write loads lock/QE/level 1");
        issue(3'd1, 8,  8'h00, '0, 1'b1, 1'b0, 1'b1, 8'hC7, "R7 enable while busy");
        issue(3'd7, 8,  8'h00, '0, 1'b1, 1'b0, 1'b0, 8'hC7, "R7 status read while busy");
        issue(3'd0, 40, 8'h00, '0, 1'b1, 1'b0, 1'b0, 8'hC7, "R11 array read no pulse");
        finish_op(8'hC4, "R8 done clears busy and latch");
        issue(3'd1, 8,  8'h00, '0, 1'b1, 1'b1, 1'b0, 8'hC6, "R2 enable after done");
        issue(3'd3, 16, 8'h00, '0, 1'b0, 1'b0, 1'b1, 8'hC6, "R5 locked status write with wp low");
        issue(3'd3, 16, 8'h0C, '0, 1'b1, 1'b1, 1'b0, 8'h0F, "R4 status write with wp high, level 3");
        finish_op(8'h0C, "R8 done after status write");

        issue(3'd1, 8,  8'h00, '0, 1'b1, 1'b1, 1'b0, 8'h0E, "R2 enable level 3");
        issue(3'd4, 40, 8'h00, 22'h3C0010, 1'b1, 1'b0, 1'b1, 8'h0E, "R9 program in top 4 blocks");
        issue(3'd5, 32, 8'h00, 22'h3BFFFF, 1'b1, 1'b1, 1'b0, 8'h0F, "R9 erase just below area");
        finish_op(8'h0C, "R8 done after erase");
        issue(3'd1, 8,  8'h00, '0, 1'b1, 1'b1, 1'b0, 8'h0E, "R2 enable");
        issue(3'd6, 8,  8'h00, '0, 1'b1, 1'b0, 1'b1, 8'h0E, "R10 chip erase with level 3");
        issue(3'd4, 41, 8'h00, '0, 1'b1, 1'b0, 1'b1, 8'h0E, "R3 program 41 bits");
        issue(3'd5, 40, 8'h00, '0, 1'b1, 1'b0, 1'b1, 8'h0E, "R3 erase 40 bits");
        issue(3'd4, 2080, 8'h00, '0, 1'b1, 1'b1, 1'b0, 8'h0F, "R9 long program outside area");
        finish_op(8'h0C, "R8 done after program");
        issue(3'd5, 32, 8'h00, '0, 1'b1, 1'b0, 1'b1, 8'h0C, "R6 erase without latch");

        issue(3'd1, 8,  8'h00, '0, 1'b1, 1'b1, 1'b0, 8'h0E, "R2 enable");
        issue(3'd3, 16, 8'h00, '0, 1'b1, 1'b1, 1'b0, 8'h03, "R4 clear level");
        finish_op(8'h00, "R8 done");
        issue(3'd1, 8,  8'h00, '0, 1'b1, 1'b1, 1'b0, 8'h02, "R2 enable");
        issue(3'd6, 8,  8'h00, '0, 1'b1, 1'b1, 1'b0, 8'h03, "R10 chip erase unprotected");
        finish_op(8'h00, "R8 done after chip erase");

        issue(3'd1, 8,  8'h00, '0, 1'b1, 1'b1, 1'b0, 8'h02, "R2 enable");
        issue(3'd3, 16, 8'h04, '0, 1'b1, 1'b1, 1'b0, 8'h07, "R4 set level 1");
        finish_op(8'h04, "R8 done");
        issue(3'd1, 8,  8'h00, '0, 1'b1, 1'b1, 1'b0, 8'h06, "R2 enable");
        issue(3'd5, 32, 8'h00, 22'h3F0000, 1'b1, 1'b0, 1'b1, 8'h06, "R9 erase top block level 1");
        issue(3'd5, 32, 8'h00, 22'h3EFFFF, 1'b1, 1'b1, 1'b0, 8'h07, "R9 erase next block level 1");
        finish_op(8'h04, "R8 done");
        finish_op(8'h04, "R8 done when idle has no effect");

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule